// File: doc/BRIEF.md
# Fixed-Point PI Speed Controller with Trapezoidal Integrator

This block is a discrete proportional-integral regulator for a speed loop. On each sample strobe it captures the set-point and the measured feedback and forms the error as set-point minus feedback. Two terms are built in parallel from that error: a proportional term and an integral term. The integral is advanced with the trapezoidal rule from the current and previous errors. The output is the sum of the two terms, limited to a programmable window.

The integral gain input is expected to be already scaled by half the sampling period. The hardware therefore performs only one multiply per term. All data ports are signed two's-complement values with `FRAC` fraction bits. The integrator is held in a wider register. A clamping anti-windup rule stops the integrator from growing further in the direction that is already driving the output into a limit.

Gains, set-point and limits are quasi-static register inputs. Feedback changes every sample. The block is fully pipelined, so a new sample may be strobed on every clock.

Top module: `pi_speed_ctrl`

## Requirements
- R1: On a strobe the error is e = setpoint − feedback, computed without overflow. The proportional term is floor(kp·e / 2^FRAC), an arithmetic right shift by FRAC.
- R2: The candidate integrator is I + floor(kic·(e + e_prev) / 2^FRAC). Here e_prev is the error of the previous strobed sample, and kic is the pre-scaled integral coefficient. The candidate is saturated to the signed AW-bit range.
- R3: The output is the proportional term plus the candidate integrator, limited to [out_min, out_max]. The maximum is tested first, so out_max wins if the limits cross.
- R4: Anti-windup works as follows. If that sum exceeds out_max and the increment is positive, the integrator keeps its old value. If the sum is below out_min and the increment is negative, the integrator also keeps its old value. Otherwise it takes the candidate.
- R5: valid_o is a one-cycle pulse on the second rising edge after the edge that sampled sample_i high. Strobes on consecutive cycles each yield their own pulse, in order.
- R6: Reset clears the integrator, the stored previous error, the output word and valid_o to zero.
- R7: Between strobes, ctrl_o and the integrator hold their values, whatever the set-point, feedback and gains do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | Sample strobe, one computation per high cycle |
| setpoint_i | input | DW | Speed target, signed |
| feedback_i | input | DW | Measured speed, signed |
| kp_i | input | DW | Proportional gain, signed, FRAC fraction bits |
| kic_i | input | DW | Integral coefficient already multiplied by T/2, signed |
| out_min_i | input | DW | Lower output limit, signed |
| out_max_i | input | DW | Upper output limit, signed |
| ctrl_o | output | DW | Saturated control word |
| valid_o | output | 1 | One-cycle pulse marking a new ctrl_o |

## Verification
Two functions can fall in the same clock cycle. The first is capturing a new sample's error. The second is the integral update of the previous sample, which reads the stored error as e_prev. The bench provokes this with strobes on consecutive cycles and checks both results against an arithmetic model in which each sample sees its predecessor's error. A second overlap is saturation combined with the anti-windup hold. Long runs with a large error drive the output into a narrow window, and the error is then reversed. A design that kept integrating while saturated would respond late, and its output would diverge from the model.

// File: rtl/pi_ctrl_pkg.sv
package pi_ctrl_pkg;

    // Limit a wide signed value into [lo, hi]; upper bound is tested first.
    function automatic logic signed [63:0] clamp_wide(
        input logic signed [63:0] v,
        input logic signed [63:0] lo,
        input logic signed [63:0] hi
    );
        if (v > hi) begin
            return hi;
        end
        if (v < lo) begin
            return lo;
        end
        return v;
    endfunction

endpackage

// File: rtl/pi_terms.sv
module pi_terms #(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int SW   = 36
) (
    input  logic signed [DW:0]   err_i,
    input  logic signed [DW:0]   prev_i,
    input  logic signed [DW-1:0] kp_i,
    input  logic signed [DW-1:0] kic_i,
    output logic signed [SW-1:0] p_term_o,
    output logic signed [SW-1:0] inc_term_o
);
    localparam int EW = DW + 2;
    localparam int PW = DW + DW + 1;
    localparam int IW = DW + EW;

    logic signed [EW-1:0] esum;
    logic signed [PW-1:0] prod_p;
    logic signed [IW-1:0] prod_i;
    logic signed [SW-1:0] p_wide;
    logic signed [SW-1:0] i_wide;

    always_comb begin
        esum       = EW'(err_i) + EW'(prev_i);
        prod_p     = PW'(kp_i) * PW'(err_i);
        prod_i     = IW'(kic_i) * IW'(esum);
        p_wide     = SW'(prod_p);
        i_wide     = SW'(prod_i);
        p_term_o   = p_wide >>> FRAC;
        inc_term_o = i_wide >>> FRAC;
    end

endmodule

// File: rtl/pi_limit.sv
module pi_limit
    import pi_ctrl_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 32,
    parameter int SW = 36
) (
    input  logic signed [SW-1:0] p_term_i,
    input  logic signed [SW-1:0] inc_term_i,
    input  logic signed [AW-1:0] integ_i,
    input  logic signed [DW-1:0] lo_i,
    input  logic signed [DW-1:0] hi_i,
    output logic signed [AW-1:0] integ_o,
    output logic signed [DW-1:0] out_o
);
    localparam logic signed [63:0] IMAX = (64'sd1 <<< (AW - 1)) - 64'sd1;
    localparam logic signed [63:0] IMIN = -(64'sd1 <<< (AW - 1));

    logic signed [63:0] cand_raw;
    logic signed [63:0] cand_sat;
    logic signed [63:0] total;
    logic signed [63:0] lo_w;
    logic signed [63:0] hi_w;
    logic signed [63:0] lim;
    logic               push_up;
    logic               push_down;

    always_comb begin
        lo_w      = 64'(lo_i);
        hi_w      = 64'(hi_i);
        cand_raw  = 64'(integ_i) + 64'(inc_term_i);
        cand_sat  = clamp_wide(cand_raw, IMIN, IMAX);
        total     = 64'(p_term_i) + cand_sat;
        push_up   = (total > hi_w) && (inc_term_i > 0);
        push_down = (total < lo_w) && (inc_term_i < 0);
        integ_o   = (push_up || push_down) ? integ_i : cand_sat[AW-1:0];
        lim       = clamp_wide(total, lo_w, hi_w);
        out_o     = lim[DW-1:0];
    end

endmodule

// File: rtl/pi_speed_ctrl.sv
module pi_speed_ctrl #(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int AW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_i,
    input  logic signed [DW-1:0] setpoint_i,
    input  logic signed [DW-1:0] feedback_i,
    input  logic signed [DW-1:0] kp_i,
    input  logic signed [DW-1:0] kic_i,
    input  logic signed [DW-1:0] out_min_i,
    input  logic signed [DW-1:0] out_max_i,
    output logic signed [DW-1:0] ctrl_o,
    output logic                 valid_o
);
    localparam int PW   = DW + DW + 2;
    localparam int WIDE = (AW > PW) ? AW : PW;
    localparam int SW   = WIDE + 2;

    typedef struct packed {
        logic signed [DW:0]   err;
        logic signed [DW:0]   prev;
        logic signed [AW-1:0] integ;
        logic                 busy;
        logic signed [DW-1:0] out;
        logic                 vld;
    } state_t;

    state_t state_d, state_q;

    logic signed [SW-1:0] p_term;
    logic signed [SW-1:0] inc_term;
    logic signed [AW-1:0] integ_nx;
    logic signed [DW-1:0] out_nx;
    logic signed [AW-1:0] integ_state;

    pi_terms #(
        .DW  (DW),
        .FRAC(FRAC),
        .SW  (SW)
    ) i_terms (
        .err_i     (state_q.err),
        .prev_i    (state_q.prev),
        .kp_i      (kp_i),
        .kic_i     (kic_i),
        .p_term_o  (p_term),
        .inc_term_o(inc_term)
    );

    pi_limit #(
        .DW(DW),
        .AW(AW),
        .SW(SW)
    ) i_limit (
        .p_term_i  (p_term),
        .inc_term_i(inc_term),
        .integ_i   (state_q.integ),
        .lo_i      (out_min_i),
        .hi_i      (out_max_i),
        .integ_o   (integ_nx),
        .out_o     (out_nx)
    );

    always_comb begin
        state_d      = state_q;
        state_d.vld  = 1'b0;
        state_d.busy = sample_i;
        if (sample_i) begin
            state_d.err = (DW+1)'(setpoint_i) - (DW+1)'(feedback_i);
        end
        if (state_q.busy) begin
            state_d.prev  = state_q.err;
            state_d.integ = integ_nx;
            state_d.out   = out_nx;
            state_d.vld   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl_o      = state_q.out;
    assign valid_o     = state_q.vld;
    assign integ_state = state_q.integ;

endmodule

// File: rtl/pi_speed_ctrl_chk.sv
module pi_speed_ctrl_chk #(
    parameter int DW = 16,
    parameter int AW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_i,
    input logic                 valid_o,
    input logic signed [DW-1:0] ctrl_o,
    input logic signed [DW-1:0] out_min_i,
    input logic signed [DW-1:0] out_max_i,
    input logic signed [AW-1:0] integ_state
);

    AST_OUT_WITHIN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && out_min_i <= out_max_i) |-> (ctrl_o >= out_min_i && ctrl_o <= out_max_i)); // R3

    AST_VALID_TWO_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |=> ##1 valid_o); // R5

    AST_INTEG_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(integ_state)); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && integ_state == '0)); // R6

endmodule

bind pi_speed_ctrl pi_speed_ctrl_chk #(
    .DW(DW),
    .AW(AW)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_i   (sample_i),
    .valid_o    (valid_o),
    .ctrl_o     (ctrl_o),
    .out_min_i  (out_min_i),
    .out_max_i  (out_max_i),
    .integ_state(integ_state)
);

// File: tb/test_pi_speed_ctrl.sv
module test_pi_speed_ctrl;
    localparam int DW   = 16;
    localparam int FRAC = 8;
    localparam int AW   = 32;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sample_r = 1'b0;
    logic signed [DW-1:0] sp_r = '0;
    logic signed [DW-1:0] fb_r = '0;
    logic signed [DW-1:0] kp_r = '0;
    logic signed [DW-1:0] kic_r = '0;
    logic signed [DW-1:0] lo_r = '0;
    logic signed [DW-1:0] hi_r = '0;
    logic signed [DW-1:0] ctrl;
    logic                 valid;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    longint m_int = 0;
    longint m_prev = 0;

    always #10 clk = ~clk;

    pi_speed_ctrl #(.DW(DW), .FRAC(FRAC), .AW(AW)) i_pi_speed_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (sample_r),
        .setpoint_i(sp_r),
        .feedback_i(fb_r),
        .kp_i      (kp_r),
        .kic_i     (kic_r),
        .out_min_i (lo_r),
        .out_max_i (hi_r),
        .ctrl_o    (ctrl),
        .valid_o   (valid)
    );

    task automatic cmp(input string req, input longint got, input longint exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Arithmetic reference: returns the expected output for feedback fb.
    function automatic longint model(input longint fb);
        longint e, p, inc, cand, tot, lim;
        longint imax, imin;
        imax = (64'sd1 <<< (AW - 1)) - 1;
        imin = -(64'sd1 <<< (AW - 1));
        e    = longint'(sp_r) - fb;
        p    = (longint'(kp_r) * e) >>> FRAC;
        inc  = (longint'(kic_r) * (e + m_prev)) >>> FRAC;
        cand = m_int + inc;
        if (cand > imax) cand = imax;
        if (cand < imin) cand = imin;
        tot = p + cand;
        if (!((tot > hi_r && inc > 0) || (tot < lo_r && inc < 0))) m_int = cand;
        m_prev = e;
        lim = tot;
        if (tot > hi_r) lim = hi_r;
        else if (tot < lo_r) lim = lo_r;
        return lim;
    endfunction

    task automatic one_sample(input longint fb, input string req);
        longint exp;
        @(negedge clk);
        fb_r     = DW'(fb);
        sample_r = 1'b1;
        exp      = model(fb);
        @(negedge clk);
        sample_r = 1'b0;
        @(negedge clk);
        cmp({req, " valid pulse"}, longint'(valid), 1);
        cmp({req, " output"}, longint'(ctrl), exp);
        @(negedge clk);
        cmp("R5 pulse single cycle", longint'(valid), 0);
        cmp("R7 output held", longint'(ctrl), exp);
    endtask

    task automatic set_cfg(input int sp, input int kp, input int kic, input int lo, input int hi);
        @(negedge clk);
        sp_r  = DW'(sp);
        kp_r  = DW'(kp);
        kic_r = DW'(kic);
        lo_r  = DW'(lo);
        hi_r  = DW'(hi);
    endtask

    initial begin
        longint ea, eb, held;
        repeat (3) @(negedge clk);
        cmp("R6 reset output", longint'(ctrl), 0);
        cmp("R6 reset valid", longint'(valid), 0);
        rst_n = 1'b1;

        // R1 R3: proportional only, sweep feedback, wide limits
        set_cfg(1000, 384, 0, -20000, 20000);
        for (int s = 0; s < 24; s++) one_sample(-3000 + s * 257, "R1");

        // R2: trapezoidal integration with several gain sets
        for (int g = 0; g < 4; g++) begin
            set_cfg(500 - g * 300, 64 + g * 96, 16 + g * 40, -30000, 30000);
            for (int s = 0; s < 16; s++) one_sample(-800 + s * 113 - g * 50, "R2");
        end

        // R3 R4: narrow window, drive into upper limit then reverse
        set_cfg(1000, 256, 200, -1500, 1500);
        for (int s = 0; s < 20; s++) one_sample(-2000, "R4 windup");
        for (int s = 0; s < 10; s++) one_sample(3000, "R4 recovery");
        for (int s = 0; s < 10; s++) one_sample(-2500 + s * 500, "R3");

        // R3: crossed limits, upper bound wins
        set_cfg(0, 256, 0, 100, -100);
        one_sample(-50, "R3 crossed");
        one_sample(50, "R3 crossed");

        // R5: back-to-back strobes
        set_cfg(200, 300, 50, -20000, 20000);
        @(negedge clk);
        fb_r = 16'sd40;  sample_r = 1'b1; ea = model(40);
        @(negedge clk);
        fb_r = -16'sd90; eb = model(-90);
        @(negedge clk);
        sample_r = 1'b0;
        cmp("R5 first of pair valid", longint'(valid), 1);
        cmp("R5 first of pair", longint'(ctrl), ea);
        @(negedge clk);
        cmp("R5 second of pair valid", longint'(valid), 1);
        cmp("R5 second of pair", longint'(ctrl), eb);
        @(negedge clk);
        cmp("R5 pair ends", longint'(valid), 0);

        // R7: inputs move with no strobe
        held = eb;
        for (int s = 0; s < 6; s++) begin
            @(negedge clk);
            fb_r = DW'(s * 999 - 2000);
            sp_r = DW'(s * 77);
            @(negedge clk);
            cmp("R7 no valid without strobe", longint'(valid), 0);
            cmp("R7 output unchanged", longint'(ctrl), held);
        end
        set_cfg(200, 300, 50, -20000, 20000);
        one_sample(10, "R7 integrator untouched");

        // R6: reset mid-run clears integrator and previous error
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        cmp("R6 output cleared", longint'(ctrl), 0);
        cmp("R6 valid cleared", longint'(valid), 0);
        rst_n  = 1'b1;
        m_int  = 0;
        m_prev = 0;
        one_sample(-300, "R6 fresh state");
        one_sample(-100, "R6 fresh state");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule